// File: doc/BRIEF.md
# SPI Slave Shifter for Clock Phase One

This block is the serial side of an 8-bit SPI slave that works only in the clock-phase-one format: in every bit time the first serial clock edge moves a transmit bit onto MISO and the second edge captures MOSI. A polarity input sets the idle level of the serial clock. An order input selects most-significant-bit-first or least-significant-bit-first, and the same choice applies to both directions. The serial clock, the active-low slave select and MOSI arrive from pins and are brought into the system clock domain through two-flop synchronisers. All edge detection then happens on the system clock. The system clock must run at least four times faster than the serial clock.

The host side loads the next transmit byte through a one-cycle load strobe into a holding register. Each transfer reuses that byte until it is replaced. Each completed byte appears on a receive bus with a one-cycle valid strobe. MISO is enabled as soon as slave select is seen low. Until the first serial clock edge MISO carries no meaningful data and is driven low. When slave select rises before the eighth capture edge, the partial byte is dropped and the next transfer starts again at bit zero.

Top module: `spi_cpha1_slave`

## Requirements
- R1: `miso_oe` is 1 within three system clock cycles after `ss_n_in` falls and 0 within three cycles after it rises.
- R2: After reset, `rx_valid`, `miso_oe` and `miso` are all 0.
- R3: The first clock edge of a transfer puts the first transmit bit of the held byte on `miso`. That bit is bit 7 when `lsb_first` is 0 and bit 0 when `lsb_first` is 1.
- R4: Each later leading edge moves `miso` to the next bit in the selected order, and `miso` does not change between leading edges.
- R5: MOSI is captured on the second (trailing) edge of each bit time. The first captured bit becomes bit 7 of the received byte when `lsb_first` is 0 and bit 0 when `lsb_first` is 1.
- R6: After the eighth capture edge, `rx_valid` is 1 for exactly one system clock cycle with the received byte on `rx_data`.
- R7: With `cpol` at 0 the serial clock idles low and leading edges are rising. With `cpol` at 1 it idles high and leading edges are falling.
- R8: When slave select rises before the eighth capture edge, no `rx_valid` pulse is produced and the next transfer starts again with the first bit of the held byte.
- R9: A `tx_load` pulse captures `tx_data`. That byte is sent in every later transfer until another load replaces it.
- R10: `miso` is 0 whenever `miso_oe` has been 0 for more than one cycle.
- R11: Serial clock edges that arrive while slave select is high have no effect. They produce no `rx_valid` and do not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_in | input | 1 | Active-low slave select (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| cpol | input | 1 | Idle level of the serial clock |
| lsb_first | input | 1 | 0: bit 7 first, 1: bit 0 first |
| tx_data | input | 8 | Next transmit byte |
| tx_load | input | 1 | One-cycle strobe that captures `tx_data` |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad |

## Verification
The hardest case to reach from the ports is a transfer that is cut short. Slave select must rise after some capture edges and before the eighth, and the next transfer must then be seen to start again at bit zero, both for received data and for the first MISO bit. The stimulus reaches this case with a directed abort after three bits, followed by a full transfer whose bytes are checked. It also sends clock edges while slave select is high, and it runs seeded random transfers that mix polarity, bit order and whether a new byte is loaded.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the phase-one SPI slave.
// Assumes: one byte per transfer; bit order is chosen per transfer.
package spi_slv_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
// Module: spi_slv_sync
// Brings a group of asynchronous inputs into the clk domain through a
// chain of STAGES flops.
// Assumes: each bit is independently asynchronous, and STAGES >= 1.
module spi_slv_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Purpose: shift the inputs through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_slv_edge.sv
`timescale 1ns/1ps
// Module: spi_slv_edge
// Finds serial clock edges in the clk domain and classifies them by
// polarity. A leading edge leaves the idle level (the launch edge in
// phase one). A trailing edge returns to the idle level (the capture edge).
// Assumes: sclk_s is already synchronised and cpol is stable during a transfer.
module spi_slv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    output logic drive_ev,
    output logic sample_ev
);
    logic sclk_prev;

    // Purpose: remember last cycle's synchronised serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign drive_ev  = (sclk_s != cpol) && (sclk_prev == cpol);
    assign sample_ev = (sclk_s == cpol) && (sclk_prev != cpol);
endmodule

// File: rtl/spi_slv_shifter.sv
`timescale 1ns/1ps
// Module: spi_slv_shifter
// Holds the transmit byte, shifts it out on leading edges, assembles the
// received byte on trailing edges and raises a one-cycle valid strobe.
// Assumes: event inputs are one-cycle pulses in the clk domain, and
// ss_s high means the slave is not selected.
module spi_slv_shifter
    import spi_slv_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              mosi_s,
    input  logic              drive_ev,
    input  logic              sample_ev,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              miso_q
);
    localparam int              CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    order_e            order;
    logic [DATA_W-1:0] tx_hold;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] tx_cur;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [CNT_W-1:0]  bit_cnt;

    assign order = order_e'(lsb_first);

    // Purpose: the first bit of a transfer comes from the holding register.
    assign tx_cur = (bit_cnt == '0) ? tx_hold : tx_sh;

    // Purpose: received byte after inserting the current MOSI bit.
    assign rx_next = (order == ORDER_LSB) ? {mosi_s, rx_sh[DATA_W-1:1]}
                                          : {rx_sh[DATA_W-2:0], mosi_s};

    // Purpose: capture the host's next transmit byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_hold <= '0;
        else if (tx_load) tx_hold <= tx_data;
    end

    // Purpose: shift both directions, count bits, abort on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            bit_cnt  <= '0;
            miso_q   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (ss_s) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (drive_ev) begin
                    if (order == ORDER_LSB) begin
                        miso_q <= tx_cur[0];
                        tx_sh  <= tx_cur >> 1;
                    end else begin
                        miso_q <= tx_cur[DATA_W-1];
                        tx_sh  <= tx_cur << 1;
                    end
                end
                if (sample_ev) begin
                    rx_sh <= rx_next;
                    if (bit_cnt == LAST_BIT) begin
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                        bit_cnt  <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (bit_cnt == '0)); // R8
    AST_VALID_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!ss_s)); // R11
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_ev && !ss_s) |=> $stable(miso_q)); // R4
endmodule

// File: rtl/spi_cpha1_slave.sv
`timescale 1ns/1ps
// Module: spi_cpha1_slave
// Top of the phase-one SPI slave: synchronisers, edge classifier and
// shifter. MISO is enabled while synchronised slave select is low.
// Assumes: clk runs at least four times the serial clock rate, and cpol
// and lsb_first change only while slave select is high.
module spi_cpha1_slave
    import spi_slv_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              miso,
    output logic              miso_oe
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             sclk_s;
    logic             ss_s;
    logic             mosi_s;
    logic             drive_ev;
    logic             sample_ev;
    logic             miso_q;

    spi_slv_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mosi_in, ss_n_in, sclk_in}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign ss_s   = pins_s[1];
    assign mosi_s = pins_s[2];

    spi_slv_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cpol      (cpol),
        .drive_ev  (drive_ev),
        .sample_ev (sample_ev)
    );

    spi_slv_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_s      (ss_s),
        .mosi_s    (mosi_s),
        .drive_ev  (drive_ev),
        .sample_ev (sample_ev),
        .lsb_first (lsb_first),
        .tx_data   (tx_data),
        .tx_load   (tx_load),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .miso_q    (miso_q)
    );

    // Purpose: pad enable follows synchronised slave select.
    assign miso_oe = ~ss_s;
    assign miso    = miso_q;

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!miso_oe && $past(!miso_oe)) |-> !miso); // R10
    AST_OE_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!miso_oe && $past(!miso_oe)) |-> !rx_valid); // R11
endmodule

// File: tb/spi_cpha1_slave_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random transfers, checked
// against bit orders computed here from the requirements.
module spi_cpha1_slave_bench;
    localparam int HALF = 4; // system cycles per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic       cpol = 1'b0;
    logic       lsb_first = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       miso;
    logic       miso_oe;

    int checks = 0;
    int errors = 0;
    int rx_count = 0;
    logic [7:0] last_rx = 8'h00;
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_cpha1_slave u_spi_cpha1_slave (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ss_n_in(ss_n_in),
        .mosi_in(mosi_in), .cpol(cpol), .lsb_first(lsb_first),
        .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data),
        .rx_valid(rx_valid), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [7:0] b, input logic lsb, input int i);
        return lsb ? b[i] : b[7-i];
    endfunction

    // Receive monitor: counts valid strobes and flags wide strobes (R6).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_count++;
            last_rx = rx_data;
            if (prev_valid) check(1'b0, "R6 strobe width", 2, 1);
        end
        prev_valid = rx_valid;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_data = b;
        tx_load = 1'b1;
        cycles(1);
        tx_load = 1'b0;
    endtask

    task automatic set_mode(input logic p, input logic lsb);
        cpol = p;
        lsb_first = lsb;
        sclk_in = p;
        cycles(6);
    endtask

    // Runs nbits bit times; checks MISO after each leading edge and the
    // outcome after deselect.
    task automatic transfer(input logic [7:0] tx, input logic [7:0] rx, input int nbits);
        int cnt0;
        cnt0 = rx_count;
        ss_n_in = 1'b0;
        cycles(HALF);
        check(miso_oe == 1'b1, "R1 oe on select", int'(miso_oe), 1);
        for (int i = 0; i < nbits; i++) begin
            sclk_in = ~cpol;
            mosi_in = bit_at(rx, lsb_first, i);
            cycles(HALF);
            if (i == 0)
                check(miso == bit_at(tx, lsb_first, 0),
                      cpol ? "R3 R7 first bit cpol1" : "R3 R7 first bit cpol0",
                      int'(miso), int'(bit_at(tx, lsb_first, 0)));
            else
                check(miso == bit_at(tx, lsb_first, i), "R4 next bit",
                      int'(miso), int'(bit_at(tx, lsb_first, i)));
            sclk_in = cpol;
            cycles(HALF);
        end
        cycles(2);
        ss_n_in = 1'b1;
        cycles(HALF);
        check(miso_oe == 1'b0, "R1 oe off on deselect", int'(miso_oe), 0);
        check(miso == 1'b0, "R10 miso quiet", int'(miso), 0);
        if (nbits == 8) begin
            check(rx_count == cnt0 + 1, "R6 one strobe", rx_count - cnt0, 1);
            check(last_rx == rx, "R5 received byte", int'(last_rx), int'(rx));
        end else begin
            check(rx_count == cnt0, "R8 no strobe on abort", rx_count - cnt0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        check(rx_valid == 1'b0, "R2 reset valid", int'(rx_valid), 0);
        check(miso_oe == 1'b0, "R2 reset oe", int'(miso_oe), 0);
        check(miso == 1'b0, "R2 reset miso", int'(miso), 0);

        // Directed: MSB first, idle low.
        set_mode(1'b0, 1'b0);
        load_tx(8'hA5);
        transfer(8'hA5, 8'h3C, 8);
        // Directed: LSB first, idle high.
        set_mode(1'b1, 1'b1);
        load_tx(8'h81);
        transfer(8'h81, 8'hC3, 8);
        // R9: no reload, same byte again.
        transfer(8'h81, 8'h5A, 8);
        // R8: abort after three bits, then full transfer restarts at bit 0.
        set_mode(1'b0, 1'b0);
        load_tx(8'h6E);
        transfer(8'h6E, 8'hF0, 3);
        transfer(8'h6E, 8'h0F, 8);
        // R11: clock edges while deselected are ignored.
        begin
            int cnt0;
            cnt0 = rx_count;
            for (int k = 0; k < 10; k++) begin
                sclk_in = ~sclk_in;
                mosi_in = k[0];
                cycles(HALF);
            end
            sclk_in = cpol;
            cycles(HALF);
            check(rx_count == cnt0, "R11 no strobe while deselected", rx_count - cnt0, 0);
            check(miso == 1'b0 && miso_oe == 1'b0, "R11 outputs idle",
                  int'({miso, miso_oe}), 0);
            transfer(8'h6E, 8'h99, 8); // R11 first bit still bit 0
        end

        // Random transfers.
        begin
            logic [7:0] held;
            held = 8'h6E;
            for (int n = 0; n < 40; n++) begin
                logic [7:0] rxb;
                set_mode(1'($urandom), 1'($urandom));
                if ($urandom % 2 == 0) begin
                    held = 8'($urandom);
                    load_tx(held);
                end
                rxb = 8'($urandom);
                if ($urandom % 8 == 0) transfer(held, rxb, 1 + int'($urandom % 7));
                else                   transfer(held, rxb, 8);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule